// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block selects the address of the next microword in a microprogrammed control unit. A control address register holds the current control-memory address. On every clock edge after reset it takes one of four values: the current address plus one, the branch address from the microword, a routine start address derived from the instruction opcode, or the contents of a one-deep return register. Each microword carries three fields that drive the choice: a condition selector, a branch kind and an address. The condition selector picks a test from the processor status and the instruction's indirect-mode bit.

In use, the control store is addressed straight from the register output. After reset the register points at the start of the fetch routine, which advances by increment. A branch qualified on the indirect bit can divert it to an operand-address routine, and a map operation enters the opcode's execute routine. Each execute routine ends with an unconditional jump back to the fetch start. The return register lives outside the read-only control store, so microcode can call a shared routine and come back to the word after the call.

Top module: `uaddr_seq`

## Requirements
- R1: While reset (synchronous, active high) is sampled high, the address register loads 0x40, which is the first word of the fetch routine. The return register also loads 0x40.
- R2: When the selected condition is false, the next address is the current address plus one, modulo 128. For example, 0x7F is followed by 0x00.
- R3: Branch kind 00 with condition select 00 (always true) loads the microword's 7-bit address field.
- R4: The condition select encodes the test as follows: 00 is always true, 01 is the indirect-mode bit, 10 is the sign status and 11 is the zero status. Every branch kind (00, 01, 10, 11) is performed only when its test is true. Otherwise the register increments.
- R5: Branch kind 11 (map) loads {0, opcode[3:0], 00}. This gives each opcode four consecutive microwords starting at opcode×4.
- R6: Branch kind 01 (call) loads the address field and writes the current address plus one into the return register.
- R7: Branch kind 10 (return) loads the return register's value. The return register holds one level only, so a second call overwrites the first return address.
- R8: The valid output is low in the cycle after any edge with reset high. It is high after every edge with reset low.
- R9: Reset takes precedence over any microword fields presented in the same cycle, including a call. A later return therefore goes to 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| condSel | input | 2 | Condition selector from the current microword |
| brKind | input | 2 | Branch kind from the current microword |
| brAddr | input | 7 | Branch address from the current microword |
| irOpcode | input | 4 | Opcode bits of the instruction register |
| irIndirect | input | 1 | Indirect addressing-mode bit of the instruction register |
| statusSign | input | 1 | Sign status bit |
| statusZero | input | 1 | Zero status bit |
| carOut | output | 7 | Control address, drives the control-memory address |
| carValid | output | 1 | High when carOut holds a sequenced address |

## Verification
A call and a return each touch the return register. A call also coincides with the write of its own return address, so the return register and the address register change in the same cycle. The bench presents calls back to back, with a return directly after them. It also presents reset together with call fields. In every cycle a behavioural model predicts both the new address and the return contents that the next return will show. A call whose condition is false must leave the return register untouched. This is judged by a following return that lands on the older address.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    BR_JUMP = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } brKind_e;

  typedef enum logic [1:0] {
    CS_ALWAYS   = 2'b00,
    CS_INDIRECT = 2'b01,
    CS_SIGN     = 2'b10,
    CS_ZERO     = 2'b11
  } condSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeInc;
    logic takeJump;
    logic takeMap;
    logic takeRet;
    logic saveRet;
  } seqStrobe_t;

endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] condSel,
  input  logic [1:0] brKind,
  input  logic       irIndirect,
  input  logic       statusSign,
  input  logic       statusZero,
  output seqStrobe_t strb
);

  logic condTrue;

  always_comb begin
    unique case (condSel_e'(condSel))
      CS_ALWAYS:   condTrue = 1'b1;
      CS_INDIRECT: condTrue = irIndirect;
      CS_SIGN:     condTrue = statusSign;
      CS_ZERO:     condTrue = statusZero;
      default:     condTrue = 1'b1;
    endcase
  end

  always_comb begin
    strb = '0;
    if (!condTrue) begin
      strb.takeInc = 1'b1;
    end else begin
      unique case (brKind_e'(brKind))
        BR_JUMP: strb.takeJump = 1'b1;
        BR_CALL: begin
          strb.takeJump = 1'b1;
          strb.saveRet  = 1'b1;
        end
        BR_RET:  strb.takeRet = 1'b1;
        BR_MAP:  strb.takeMap = 1'b1;
        default: strb.takeInc = 1'b1;
      endcase
    end
  end

  // R4
  one_source_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot({strb.takeInc, strb.takeJump, strb.takeMap, strb.takeRet}));

  // R6
  save_with_jump_chk: assert property (@(posedge clk) disable iff (rst)
    strb.saveRet |-> (strb.takeJump && brKind == 2'b01));

endmodule

// File: rtl/useq_path.sv
module useq_path
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OP_W       = 4,
  parameter int SLOT_W     = 2,
  parameter int RESET_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] brAddr,
  input  logic [OP_W-1:0]   irOpcode,
  output logic [ADDR_W-1:0] car,
  output logic              carValid
);

  localparam int PAD_W = ADDR_W - OP_W - SLOT_W;
  localparam logic [ADDR_W-1:0] START = ADDR_W'(RESET_ADDR);

  logic [ADDR_W-1:0] retReg;
  logic [ADDR_W-1:0] carPlus;
  logic [ADDR_W-1:0] mapAddr;
  logic [ADDR_W-1:0] nextAddr;

  assign carPlus = car + 1'b1;

  generate
    if (PAD_W > 0) begin : g_pad
      assign mapAddr = {{PAD_W{1'b0}}, irOpcode, {SLOT_W{1'b0}}};
    end else begin : g_nopad
      assign mapAddr = {irOpcode, {SLOT_W{1'b0}}};
    end
  endgenerate

  always_comb begin
    if (strb.takeJump)     nextAddr = brAddr;
    else if (strb.takeMap) nextAddr = mapAddr;
    else if (strb.takeRet) nextAddr = retReg;
    else                   nextAddr = carPlus;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car      <= START;
      retReg   <= START;
      carValid <= 1'b0;
    end else begin
      car      <= nextAddr;
      carValid <= 1'b1;
      if (strb.saveRet) retReg <= carPlus;
    end
  end

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    strb.takeInc |=> car == ADDR_W'($past(car) + 1'b1));

  // R5
  map_slot_chk: assert property (@(posedge clk) disable iff (rst)
    strb.takeMap |=> (car[SLOT_W-1:0] == '0 && car[SLOT_W +: OP_W] == $past(irOpcode)));

  // R6
  call_save_chk: assert property (@(posedge clk) disable iff (rst)
    strb.saveRet |=> (retReg == ADDR_W'($past(car) + 1'b1) && car == $past(brAddr)));

  // R7
  ret_load_chk: assert property (@(posedge clk) disable iff (rst)
    strb.takeRet |=> car == $past(retReg));

  // R8
  valid_high_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> carValid);

endmodule

// File: rtl/uaddr_seq.sv
module uaddr_seq
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OP_W       = 4,
  parameter int SLOT_W     = 2,
  parameter int RESET_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        condSel,
  input  logic [1:0]        brKind,
  input  logic [ADDR_W-1:0] brAddr,
  input  logic [OP_W-1:0]   irOpcode,
  input  logic              irIndirect,
  input  logic              statusSign,
  input  logic              statusZero,
  output logic [ADDR_W-1:0] carOut,
  output logic              carValid
);

  seqStrobe_t strb;

  useq_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .condSel    (condSel),
    .brKind     (brKind),
    .irIndirect (irIndirect),
    .statusSign (statusSign),
    .statusZero (statusZero),
    .strb       (strb)
  );

  useq_path #(
    .ADDR_W     (ADDR_W),
    .OP_W       (OP_W),
    .SLOT_W     (SLOT_W),
    .RESET_ADDR (RESET_ADDR)
  ) i_path (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .brAddr   (brAddr),
    .irOpcode (irOpcode),
    .car      (carOut),
    .carValid (carValid)
  );

endmodule

// File: tb/test_uaddr_seq.sv
module test_uaddr_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] condSel = 2'b00;
  logic [1:0] brKind = 2'b00;
  logic [6:0] brAddr = 7'd0;
  logic [3:0] irOpcode = 4'd0;
  logic       irIndirect = 1'b0;
  logic       statusSign = 1'b0;
  logic       statusZero = 1'b0;
  logic [6:0] carOut;
  logic       carValid;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  int mCar = 64;
  int mRet = 64;
  int mValid = 0;

  always #5 clk = ~clk;

  uaddr_seq i_uaddr_seq (
    .clk(clk), .rst(rst), .condSel(condSel), .brKind(brKind), .brAddr(brAddr),
    .irOpcode(irOpcode), .irIndirect(irIndirect), .statusSign(statusSign),
    .statusZero(statusZero), .carOut(carOut), .carValid(carValid)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit r, int sel, int bk, int addr, int op, bit ind, bit sg, bit zr);
    bit cond;
    string tag;
    @(negedge clk);
    rst = r; condSel = 2'(sel); brKind = 2'(bk); brAddr = 7'(addr);
    irOpcode = 4'(op); irIndirect = ind; statusSign = sg; statusZero = zr;
    @(posedge clk);
    case (sel)
      0: cond = 1;
      1: cond = ind;
      2: cond = sg;
      default: cond = zr;
    endcase
    if (r) begin
      mCar = 64; mRet = 64; mValid = 0; tag = "R1";
    end else begin
      mValid = 1;
      if (!cond) begin
        mCar = (mCar + 1) % 128;
        tag = (sel != 0) ? "R4" : "R2";
      end else begin
        case (bk)
          0: begin mCar = addr; tag = (sel != 0) ? "R4" : "R3"; end
          1: begin mRet = (mCar + 1) % 128; mCar = addr; tag = "R6"; end
          2: begin mCar = mRet; tag = "R7"; end
          default: begin mCar = op * 4; tag = "R5"; end
        endcase
      end
    end
    #1;
    chk(tag, int'(carOut), mCar);
    chk("R8", int'(carValid), mValid);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    // R1 reset state
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    // R2 fetch walk by increment (condition false)
    step(0, 3, 0, 5, 0, 0, 0, 0);
    step(0, 2, 1, 9, 0, 0, 0, 0);
    // R4 indirect-qualified branch, not taken then taken
    step(0, 1, 0, 72, 0, 0, 0, 0);
    step(0, 1, 0, 72, 0, 1, 0, 0);
    // R5 map to opcode routine
    step(0, 0, 3, 0, 9, 0, 0, 0);
    step(0, 0, 3, 0, 15, 0, 0, 0);
    // R3 unconditional jump back to fetch
    step(0, 0, 0, 64, 0, 0, 0, 0);
    // R4 sign and zero tests
    step(0, 2, 0, 20, 0, 0, 1, 0);
    step(0, 3, 0, 30, 0, 0, 0, 1);
    step(0, 3, 3, 0, 7, 0, 0, 0);
    // R6 R7 call, nested call overwrites, return
    step(0, 0, 1, 100, 0, 0, 0, 0);
    step(0, 0, 1, 110, 0, 0, 0, 0);
    step(0, 2, 1, 50, 0, 0, 0, 0);
    step(0, 0, 2, 0, 0, 0, 0, 0);
    chk("R7", int'(carOut), 101);
    step(0, 0, 2, 0, 0, 0, 0, 0);
    // R2 wrap at top of space
    step(0, 0, 0, 127, 0, 0, 0, 0);
    step(0, 1, 0, 3, 0, 0, 0, 0);
    chk("R2", int'(carOut), 0);
    // R9 reset with call fields, then return lands at fetch start
    step(0, 0, 1, 90, 0, 0, 0, 0);
    step(1, 0, 1, 33, 0, 0, 0, 0);
    step(0, 0, 2, 0, 0, 0, 0, 0);
    chk("R9", int'(carOut), 64);
    // random stream
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 97) == 0, int'($urandom % 4), int'($urandom % 4),
           int'($urandom % 128), int'($urandom % 16),
           1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule